// File: doc/BRIEF.md
# USB Device IN Endpoint Status Controller

This block keeps the control and event state of eight USB device IN endpoints and folds the events into a per-endpoint summary and one interrupt line. For each endpoint it stores a maximum packet size, an active flag, the data-toggle state (DATA0/DATA1), the isochronous frame parity (even/odd), a STALL request and a NAK request. It also drives the handshake the endpoint should return.

Three kinds of event are reported per endpoint. The first is a live FIFO-empty level, chosen between half-empty and fully-empty by a global select. The second is a latched flag for an IN token that arrived while the FIFO was fully empty. The third is a latched flag showing that a requested NAK has taken effect. Software reads and writes the state through a simple word-wide port with a 5-bit address. The packet engine, FIFO storage and PHY stay outside the block and appear only as strobes and levels.

Top module: `usb_in_ep_status`

## Requirements
- R1: Addresses 0..7 select the control word of endpoint 0..7. Max packet size is in bits 10:0 and the active flag in bit 15; both are read/write. Bits 14:11 and bits 31:25 read 0. After reset every control and event word reads 0.
- R2: A one-cycle `bus_reset` pulse clears the active flag of endpoints 1..7 and leaves endpoint 0 unchanged. It wins over a software write in the same cycle.
- R3: The control word shows the data toggle in bit 16 (0 = DATA0, 1 = DATA1). Writing 1 to bit 21 forces DATA0 and writing 1 to bit 22 forces DATA1. If both are written, DATA1 results. Bits 21 and 22 read 0.
- R4: The control word shows the frame parity in bit 17 (0 = even, 1 = odd). Writing 1 to bit 23 forces even and writing 1 to bit 24 forces odd. If both are written, odd results. Bits 23 and 24 read 0.
- R5: Addresses 8..15 select the event word of endpoint 0..7. Bit 7 is a read-only copy of `fifo_half_empty[i]` when `empty_lvl_sel`=0, or of `fifo_all_empty[i]` when it is 1. Writes do not change it.
- R6: Event bit 4 sets one cycle after `in_token[i]` coincides with `fifo_all_empty[i]`=1, and does not set when the FIFO is not empty. Writing 1 clears it; writing 0 has no effect.
- R7: Event bit 6 sets one cycle after a `nak_done[i]` pulse, but only if the endpoint is active. It clears when 1 is written to event bit 6, or when 1 is written to control bit 20. A control write with bit 20 set also clears the NAK request.
- R8: Control bit 18 is the STALL request and bit 19 the NAK request, both read/write. `hs_stall[i]` follows bit 18. `hs_nak[i]` is bit 19 AND NOT bit 18.
- R9: When a set event and a write-1 clear hit the same event flag in the same cycle, the flag ends up set.
- R10: `ep_summary[i]` is the OR of event bits 7, 6 and 4 of endpoint i, and address 16 reads it in bits 7:0. `in_ep_irq` is the OR of the summary bits. Clearing the leaf flags clears both. Event-word bits 31:8, 5 and 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset detected, one-cycle strobe |
| empty_lvl_sel | input | 1 | 0 = half-empty, 1 = fully-empty FIFO threshold |
| fifo_half_empty | input | 8 | Per-endpoint FIFO half-empty level |
| fifo_all_empty | input | 8 | Per-endpoint FIFO fully-empty level |
| in_token | input | 8 | Per-endpoint IN token received strobe |
| nak_done | input | 8 | Per-endpoint NAK-taken-effect strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ep_summary | output | 8 | Per-endpoint pending summary |
| in_ep_irq | output | 1 | Global IN endpoint interrupt |
| hs_stall | output | 8 | Endpoint should answer STALL |
| hs_nak | output | 8 | Endpoint should answer NAK |

## Verification
A hardware set and a software write-1 clear can land on the same event flag in the same cycle. This is also true of a bus reset and a software write to the active flag. The bench provokes each pair by raising `in_token`, `nak_done` or `bus_reset` in the same cycle as the clearing or setting register write. It then reads the event or control word back on the next cycle. A set flag and a cleared active flag on endpoints other than 0 are the expected outcomes.

// File: rtl/usb_in_ep_status.sv
module usb_in_ep_status #(
  parameter int NUM_EP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              empty_lvl_sel,
  input  logic [NUM_EP-1:0] fifo_half_empty,
  input  logic [NUM_EP-1:0] fifo_all_empty,
  input  logic [NUM_EP-1:0] in_token,
  input  logic [NUM_EP-1:0] nak_done,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_EP-1:0] ep_summary,
  output logic              in_ep_irq,
  output logic [NUM_EP-1:0] hs_stall,
  output logic [NUM_EP-1:0] hs_nak
);
  localparam int MPS_W = 11;
  localparam int EVT_BASE = 8;
  localparam int SUM_ADDR = 16;

  logic [MPS_W-1:0]  mps [NUM_EP];
  logic [NUM_EP-1:0] active, pid, odd, stall, nak_req, nak_eff, tok_flag;
  logic [NUM_EP-1:0] wr_ctl, wr_evt;

  wire [NUM_EP-1:0] lvl = empty_lvl_sel ? fifo_all_empty : fifo_half_empty;
  wire unused_wbits = ^{wdata[31:25], wdata[14:11]};

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      wr_ctl[i] = wr_en && (addr == 5'(i));
      wr_evt[i] = wr_en && (addr == 5'(EVT_BASE + i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= '0;
      pid      <= '0;
      odd      <= '0;
      stall    <= '0;
      nak_req  <= '0;
      nak_eff  <= '0;
      tok_flag <= '0;
      for (int i = 0; i < NUM_EP; i++) mps[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (wr_ctl[i]) begin
          mps[i]     <= wdata[MPS_W-1:0];
          active[i]  <= wdata[15];
          stall[i]   <= wdata[18];
          nak_req[i] <= wdata[19] & ~wdata[20];
          if (wdata[22])      pid[i] <= 1'b1;
          else if (wdata[21]) pid[i] <= 1'b0;
          if (wdata[24])      odd[i] <= 1'b1;
          else if (wdata[23]) odd[i] <= 1'b0;
        end
        if (bus_reset && i != 0) active[i] <= 1'b0;
        nak_eff[i] <= (nak_done[i] & active[i]) |
                      (nak_eff[i] & ~(wr_evt[i] & wdata[6]) & ~(wr_ctl[i] & wdata[20]));
        tok_flag[i] <= (in_token[i] & fifo_all_empty[i]) |
                       (tok_flag[i] & ~(wr_evt[i] & wdata[4]));
      end
    end
  end

  assign ep_summary = lvl | nak_eff | tok_flag;
  assign in_ep_irq  = |ep_summary;
  assign hs_stall   = stall;
  assign hs_nak     = nak_req & ~stall;

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (addr == 5'(i)) begin
        rdata[MPS_W-1:0] = mps[i];
        rdata[15] = active[i];
        rdata[16] = pid[i];
        rdata[17] = odd[i];
        rdata[18] = stall[i];
        rdata[19] = nak_req[i];
      end
      if (addr == 5'(EVT_BASE + i)) begin
        rdata[7] = lvl[i];
        rdata[6] = nak_eff[i];
        rdata[4] = tok_flag[i];
      end
    end
    if (addr == 5'(SUM_ADDR)) rdata[NUM_EP-1:0] = ep_summary;
  end

  assert_bus_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> active[NUM_EP-1:1] == '0);
  assert_bus_reset_keeps_ep0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !wr_ctl[0]) |=> $stable(active[0]));

  for (genvar g = 0; g < NUM_EP; g++) begin : g_chk
    assert_data1_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl[g] && wdata[22]) |=> pid[g]);
    assert_token_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt[g] && wdata[4] && !(in_token[g] && fifo_all_empty[g])) |=> !tok_flag[g]);
    assert_nak_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nak_eff[g]) |-> $past(active[g]));
    assert_stall_over_nak_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl[g] && wdata[18]) |=> !hs_nak[g]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_token[g] && fifo_all_empty[g]) |=> tok_flag[g]);
  end
endmodule

// File: tb/test_usb_in_ep_status.sv
`timescale 1ns/1ps
module test_usb_in_ep_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        empty_lvl_sel = 1'b0;
  logic [7:0]  fifo_half_empty = '0;
  logic [7:0]  fifo_all_empty = '0;
  logic [7:0]  in_token = '0;
  logic [7:0]  nak_done = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  ep_summary, hs_stall, hs_nak;
  logic        in_ep_irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_in_ep_status i_usb_in_ep_status (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .empty_lvl_sel(empty_lvl_sel),
    .fifo_half_empty(fifo_half_empty), .fifo_all_empty(fifo_all_empty),
    .in_token(in_token), .nak_done(nak_done), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ep_summary(ep_summary), .in_ep_irq(in_ep_irq),
    .hs_stall(hs_stall), .hs_nak(hs_nak));

  // {addr, wdata, expected control word read back}
  localparam logic [68:0] VEC [9] = '{
    {5'd0, 32'h0000_8040, 32'h0000_8040},
    {5'd1, 32'h0000_FFFF, 32'h0000_87FF},
    {5'd2, 32'h0040_0000, 32'h0001_0000},
    {5'd3, 32'h0100_8010, 32'h0002_8010},
    {5'd4, 32'h0060_0000, 32'h0001_0000},
    {5'd5, 32'h0004_0000, 32'h0004_0000},
    {5'd6, 32'h0008_0005, 32'h0008_0005},
    {5'd7, 32'h0180_0000, 32'h0002_0000},
    {5'd2, 32'h0020_0000, 32'h0000_0000}
  };

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a; #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_sig(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(5'd0, 32'h0, "R1 reset control");
    chk(5'd8, 32'h0, "R1 reset event");
    chk(5'd16, 32'h0, "R10 reset summary");
    chk_sig({31'b0, in_ep_irq}, 32'h0, "R10 reset irq");
    chk_sig({24'b0, hs_stall}, 32'h0, "R8 reset stall");

    for (int k = 0; k < 9; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      chk(VEC[k][68:64], VEC[k][31:0], "R1 R3 R4 control table");
    end

    chk_sig({24'b0, hs_stall}, 32'h20, "R8 stall ep5");
    chk_sig({24'b0, hs_nak}, 32'h40, "R8 nak ep6");
    wr(5'd6, 32'h000C_0005);
    chk_sig({24'b0, hs_nak}, 32'h00, "R8 stall overrides nak");
    chk_sig({24'b0, hs_stall}, 32'h60, "R8 stall ep5 ep6");

    @(negedge clk); bus_reset = 1'b1; addr = 5'd1; wdata = 32'h0000_87FF; wr_en = 1'b1;
    @(negedge clk); bus_reset = 1'b0; wr_en = 1'b0;
    chk(5'd0, 32'h0000_8040, "R2 ep0 keeps active");
    chk(5'd1, 32'h0000_07FF, "R2 ep1 cleared despite write");
    chk(5'd3, 32'h0002_0010, "R2 ep3 cleared");

    @(negedge clk); nak_done = 8'h03;
    @(negedge clk); nak_done = 8'h00;
    chk(5'd8, 32'h40, "R7 nak effective ep0");
    chk(5'd9, 32'h00, "R7 nak ignored inactive ep1");
    chk(5'd16, 32'h01, "R10 summary nak");
    chk_sig({31'b0, in_ep_irq}, 32'h1, "R10 irq nak");
    wr(5'd0, 32'h0008_8040);
    chk(5'd0, 32'h0008_8040, "R8 nak request set");
    wr(5'd0, 32'h0010_8040);
    chk(5'd0, 32'h0000_8040, "R7 clear-nak command");
    chk(5'd8, 32'h00, "R7 clear-nak clears flag");
    chk_sig({31'b0, in_ep_irq}, 32'h0, "R10 irq after clear-nak");

    fifo_all_empty = 8'h04;
    @(negedge clk); in_token = 8'h04;
    @(negedge clk); in_token = 8'h00;
    chk(5'd10, 32'h10, "R6 token flag set");
    chk(5'd16, 32'h04, "R10 summary token");
    wr(5'd10, 32'h0);
    chk(5'd10, 32'h10, "R6 write zero no effect");
    wr(5'd10, 32'hFFFF_FFEF);
    chk(5'd10, 32'h10, "R6 other bits no effect");
    wr(5'd10, 32'h10);
    chk(5'd10, 32'h00, "R6 w1c");
    chk(5'd16, 32'h00, "R10 summary after w1c");
    chk_sig({31'b0, in_ep_irq}, 32'h0, "R10 irq after w1c");
    fifo_all_empty = 8'h00;
    @(negedge clk); in_token = 8'h04;
    @(negedge clk); in_token = 8'h00;
    chk(5'd10, 32'h00, "R6 no set when fifo not empty");

    fifo_all_empty = 8'h08;
    @(negedge clk); in_token = 8'h08;
    @(negedge clk); in_token = 8'h08; addr = 5'd11; wdata = 32'h10; wr_en = 1'b1;
    @(negedge clk); in_token = 8'h00; wr_en = 1'b0;
    chk(5'd11, 32'h10, "R9 token set wins");
    wr(5'd11, 32'h10);
    chk(5'd11, 32'h00, "R9 token clear after");
    fifo_all_empty = 8'h00;
    @(negedge clk); nak_done = 8'h01; addr = 5'd8; wdata = 32'h40; wr_en = 1'b1;
    @(negedge clk); nak_done = 8'h00; wr_en = 1'b0;
    chk(5'd8, 32'h40, "R9 nak set wins");
    wr(5'd8, 32'h40);
    chk(5'd8, 32'h00, "R7 nak w1c");

    fifo_half_empty = 8'h10;
    @(negedge clk);
    chk(5'd12, 32'h80, "R5 half-empty level");
    chk(5'd16, 32'h10, "R10 summary level");
    chk_sig({31'b0, in_ep_irq}, 32'h1, "R10 irq level");
    wr(5'd12, 32'hFFFF_FFFF);
    chk(5'd12, 32'h80, "R5 write no effect");
    empty_lvl_sel = 1'b1;
    @(negedge clk);
    chk(5'd12, 32'h00, "R5 full-empty select");
    chk_sig({31'b0, in_ep_irq}, 32'h0, "R10 irq cleared");
    fifo_all_empty = 8'h10;
    @(negedge clk);
    chk(5'd12, 32'h80, "R5 full-empty level");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule